// File: doc/BRIEF.md
# External Bus Release Handshake Controller

This block decides who drives the external memory bus: the on-chip CPU bus sequencer, or an outside master that asks for the bus. The outside master pulls an active-low request line. The block passes that line through a synchroniser. It then looks at the request once per CPU bus cycle, on the clock edge that closes the cycle's first state. The CPU access already in flight is allowed to complete.

On the edge that closes the last state of that access, the block drops its active-low acknowledge. On the same edge it withdraws the output enables of every external bus pin group: address, data, the six chip selects, read strobe, both write strobes and address strobe. A stall output holds the CPU sequencer back so that it starts no new cycle. While the bus is released, the request is examined on every clock. Once it is seen high again, the acknowledge rises and the pins are driven again on one edge, and the CPU resumes.

A sleep qualifier and an all-modules-stopped qualifier come in from power management. When both are high, release is forbidden and requests are ignored.

Top module: `bus_yield_ctrl`

## Requirements
- R1: The request passes through two flip-flops that reset to the no-request level (high). The handshake acts on a low request only at a clock edge where `cyc_t1_i` is high, which is the edge that starts the second state of a CPU cycle. A request that is low only in states where `cyc_t1_i` is low is ignored.
- R2: After a low request is taken, `bus_ack_n_o` falls on the first later edge where `cyc_last_i` is high, at the close of the current CPU cycle, and not before.
- R3: While `bus_ack_n_o` is low, all seven bits of `pad_oe_o` are 0.
- R4: While released, the synchronised request is examined every clock. The first edge that sees it high raises `bus_ack_n_o` and restores the pad enables.
- R5: The released state lasts at least one clock state, even if the request was withdrawn while the block waited for the cycle to end.
- R6: `cpu_stall_o` is high from the edge that takes the request until the edge on which `bus_ack_n_o` returns high, and low otherwise.
- R7: While `sleep_i` and `mod_all_stop_i` are both high, a low request never starts a release. `bus_ack_n_o` stays high and the pads stay driven.
- R8: While `bus_ack_n_o` is high, `pad_oe_o` is all ones, except bit 1 (data), which equals `cpu_dout_en_i`. The bit order is 0 address, 1 data, 2 chip selects, 3 read, 4 high write, 5 low write, 6 address strobe. The pad value outputs always equal the matching CPU inputs.
- R9: A synchronous low `rst_n` gives `bus_ack_n_o`=1, `cpu_stall_o`=0 and the pads driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_req_n_i | input | 1 | Asynchronous active-low bus request from the outside master |
| cyc_t1_i | input | 1 | High during the first state of a CPU bus cycle |
| cyc_last_i | input | 1 | High during the final state of a CPU bus cycle |
| sleep_i | input | 1 | Device is in sleep |
| mod_all_stop_i | input | 1 | Every module-stop control is set |
| cpu_addr_i | input | ADDR_W | CPU address |
| cpu_dout_i | input | DATA_W | CPU write data |
| cpu_dout_en_i | input | 1 | CPU wants the data pins driven |
| cpu_cs_n_i | input | NCS | CPU chip selects |
| cpu_rd_n_i | input | 1 | CPU read strobe |
| cpu_hwr_n_i | input | 1 | CPU high-byte write strobe |
| cpu_lwr_n_i | input | 1 | CPU low-byte write strobe |
| cpu_as_n_i | input | 1 | CPU address strobe |
| bus_ack_n_o | output | 1 | Active-low acknowledge to the outside master |
| cpu_stall_o | output | 1 | Holds the CPU sequencer from starting cycles |
| pad_oe_o | output | 7 | Output enables per pin group |
| pad_addr_o | output | ADDR_W | Address pin values |
| pad_dout_o | output | DATA_W | Data pin values |
| pad_cs_n_o | output | NCS | Chip select pin values |
| pad_rd_n_o | output | 1 | Read strobe pin value |
| pad_hwr_n_o | output | 1 | High write strobe pin value |
| pad_lwr_n_o | output | 1 | Low write strobe pin value |
| pad_as_n_o | output | 1 | Address strobe pin value |

## Verification
Two situations are the hardest to reach from the ports. One is a request that is low only between first-state edges. The other is a request that is withdrawn while the block waits for the CPU cycle to end. Both depend on the exact phase between the synchroniser delay and the cycle position.

The stimulus sweeps cycle lengths of two to five states. For each length it places the falling request at every phase inside a cycle. It runs each placement with a one-state pulse, an early withdrawal and a long hold, and it runs the long hold under all four sleep and stop combinations. The bench computes, for every clock, the expected state of acknowledge, stall and enables from the first-state edge that sees the request.

// File: rtl/byc_pkg.sv
package byc_pkg;

  typedef enum logic [1:0] {
    BYC_OWN  = 2'd0,
    BYC_PEND = 2'd1,
    BYC_REL  = 2'd2
  } byc_state_e;

  localparam int PAD_GRPS = 7;
  localparam int GRP_ADDR = 0;
  localparam int GRP_DATA = 1;
  localparam int GRP_CS   = 2;
  localparam int GRP_RD   = 3;
  localparam int GRP_HWR  = 4;
  localparam int GRP_LWR  = 5;
  localparam int GRP_AS   = 6;

endpackage

// File: rtl/byc_sync.sv
module byc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[i] <= 1'b1;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/byc_fsm.sv
module byc_fsm
  import byc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_s_i,
  input  logic cyc_t1_i,
  input  logic cyc_last_i,
  input  logic blocked_i,
  output logic ack_n_o,
  output logic stall_o,
  output logic own_o
);

  byc_state_e state_q, state_d;
  logic       ack_n_q, stall_q, own_q;
  logic       take_req;

  // a request counts only on the edge that closes a first state
  assign take_req = cyc_t1_i && !req_n_s_i && !blocked_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BYC_OWN: begin
        if (take_req) state_d = cyc_last_i ? BYC_REL : BYC_PEND;
      end
      BYC_PEND: begin
        if (blocked_i)       state_d = BYC_OWN;
        else if (cyc_last_i) state_d = BYC_REL;
      end
      BYC_REL: begin
        if (req_n_s_i) state_d = BYC_OWN;
      end
      default: state_d = BYC_OWN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= BYC_OWN;
      ack_n_q <= 1'b1;
      stall_q <= 1'b0;
      own_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      ack_n_q <= (state_d != BYC_REL);
      stall_q <= (state_d != BYC_OWN);
      own_q   <= (state_d != BYC_REL);
    end
  end

  assign ack_n_o = ack_n_q;
  assign stall_o = stall_q;
  assign own_o   = own_q;

endmodule

// File: rtl/byc_pad_gate.sv
module byc_pad_gate
  import byc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int NCS    = 6
) (
  input  logic                bus_own_i,
  input  logic [ADDR_W-1:0]   cpu_addr_i,
  input  logic [DATA_W-1:0]   cpu_dout_i,
  input  logic                cpu_dout_en_i,
  input  logic [NCS-1:0]      cpu_cs_n_i,
  input  logic                cpu_rd_n_i,
  input  logic                cpu_hwr_n_i,
  input  logic                cpu_lwr_n_i,
  input  logic                cpu_as_n_i,
  output logic [PAD_GRPS-1:0] pad_oe_o,
  output logic [ADDR_W-1:0]   pad_addr_o,
  output logic [DATA_W-1:0]   pad_dout_o,
  output logic [NCS-1:0]      pad_cs_n_o,
  output logic                pad_rd_n_o,
  output logic                pad_hwr_n_o,
  output logic                pad_lwr_n_o,
  output logic                pad_as_n_o
);

  logic [PAD_GRPS-1:0] grp_want;

  always_comb begin
    grp_want           = '1;
    grp_want[GRP_DATA] = cpu_dout_en_i;
  end

  for (genvar g = 0; g < PAD_GRPS; g++) begin : g_oe
    assign pad_oe_o[g] = bus_own_i & grp_want[g];
  end

  assign pad_addr_o  = cpu_addr_i;
  assign pad_dout_o  = cpu_dout_i;
  assign pad_cs_n_o  = cpu_cs_n_i;
  assign pad_rd_n_o  = cpu_rd_n_i;
  assign pad_hwr_n_o = cpu_hwr_n_i;
  assign pad_lwr_n_o = cpu_lwr_n_i;
  assign pad_as_n_o  = cpu_as_n_i;

endmodule

// File: rtl/bus_yield_ctrl.sv
module bus_yield_ctrl
  import byc_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int NCS         = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_req_n_i,
  input  logic                cyc_t1_i,
  input  logic                cyc_last_i,
  input  logic                sleep_i,
  input  logic                mod_all_stop_i,
  input  logic [ADDR_W-1:0]   cpu_addr_i,
  input  logic [DATA_W-1:0]   cpu_dout_i,
  input  logic                cpu_dout_en_i,
  input  logic [NCS-1:0]      cpu_cs_n_i,
  input  logic                cpu_rd_n_i,
  input  logic                cpu_hwr_n_i,
  input  logic                cpu_lwr_n_i,
  input  logic                cpu_as_n_i,
  output logic                bus_ack_n_o,
  output logic                cpu_stall_o,
  output logic [PAD_GRPS-1:0] pad_oe_o,
  output logic [ADDR_W-1:0]   pad_addr_o,
  output logic [DATA_W-1:0]   pad_dout_o,
  output logic [NCS-1:0]      pad_cs_n_o,
  output logic                pad_rd_n_o,
  output logic                pad_hwr_n_o,
  output logic                pad_lwr_n_o,
  output logic                pad_as_n_o
);

  logic req_n_s;
  logic blocked;
  logic bus_own;

  assign blocked = sleep_i & mod_all_stop_i;

  byc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(ext_req_n_i),
    .sync_o (req_n_s)
  );

  byc_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_n_s_i (req_n_s),
    .cyc_t1_i  (cyc_t1_i),
    .cyc_last_i(cyc_last_i),
    .blocked_i (blocked),
    .ack_n_o   (bus_ack_n_o),
    .stall_o   (cpu_stall_o),
    .own_o     (bus_own)
  );

  byc_pad_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCS(NCS)) u_pads (
    .bus_own_i    (bus_own),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_dout_i   (cpu_dout_i),
    .cpu_dout_en_i(cpu_dout_en_i),
    .cpu_cs_n_i   (cpu_cs_n_i),
    .cpu_rd_n_i   (cpu_rd_n_i),
    .cpu_hwr_n_i  (cpu_hwr_n_i),
    .cpu_lwr_n_i  (cpu_lwr_n_i),
    .cpu_as_n_i   (cpu_as_n_i),
    .pad_oe_o     (pad_oe_o),
    .pad_addr_o   (pad_addr_o),
    .pad_dout_o   (pad_dout_o),
    .pad_cs_n_o   (pad_cs_n_o),
    .pad_rd_n_o   (pad_rd_n_o),
    .pad_hwr_n_o  (pad_hwr_n_o),
    .pad_lwr_n_o  (pad_lwr_n_o),
    .pad_as_n_o   (pad_as_n_o)
  );

endmodule

// File: rtl/byc_checker.sv
module byc_checker
  import byc_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                req_n_s,
  input logic                cyc_t1_i,
  input logic                cyc_last_i,
  input logic                sleep_i,
  input logic                mod_all_stop_i,
  input logic                bus_ack_n_o,
  input logic                cpu_stall_o,
  input logic                cpu_dout_en_i,
  input logic [PAD_GRPS-1:0] pad_oe_o
);

  // R1: a stall begins only after a first-state edge that saw a low request
  p_take_at_t1_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall_o) |-> ($past(cyc_t1_i) && !$past(req_n_s)));

  // R2: acknowledge falls only on an edge that closes a cycle
  p_ack_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack_n_o) |-> $past(cyc_last_i));

  // R3: every pin group floats while released
  p_float_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n_o |-> (pad_oe_o == '0));

  // R4: the bus returns only after a high request was seen
  p_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack_n_o) |-> $past(req_n_s));

  // R6: stall covers the whole released interval
  p_stall_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n_o |-> cpu_stall_o);

  // R7: no release begins while both power qualifiers are high
  p_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sleep_i && mod_all_stop_i) && $past(bus_ack_n_o)) |-> bus_ack_n_o);

  // R8: pins are driven while the CPU owns the bus
  p_driven_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack_n_o |-> (pad_oe_o[GRP_ADDR] && pad_oe_o[GRP_CS] && pad_oe_o[GRP_RD]
                     && pad_oe_o[GRP_HWR] && pad_oe_o[GRP_LWR] && pad_oe_o[GRP_AS]
                     && (pad_oe_o[GRP_DATA] == cpu_dout_en_i)));

endmodule

bind bus_yield_ctrl byc_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_n_s       (req_n_s),
  .cyc_t1_i      (cyc_t1_i),
  .cyc_last_i    (cyc_last_i),
  .sleep_i       (sleep_i),
  .mod_all_stop_i(mod_all_stop_i),
  .bus_ack_n_o   (bus_ack_n_o),
  .cpu_stall_o   (cpu_stall_o),
  .cpu_dout_en_i (cpu_dout_en_i),
  .pad_oe_o      (pad_oe_o)
);

// File: tb/tb_bus_yield_ctrl.sv
`timescale 1ns/1ps
module tb_bus_yield_ctrl;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int CS = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ext_req_n = 1'b1;
  logic          cyc_t1 = 1'b0;
  logic          cyc_last = 1'b0;
  logic          sleep_q = 1'b0;
  logic          allstop = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_dout = '0;
  logic          cpu_doe = 1'b0;
  logic [CS-1:0] cpu_cs_n = '1;
  logic          cpu_rd_n = 1'b1;
  logic          cpu_hwr_n = 1'b1;
  logic          cpu_lwr_n = 1'b1;
  logic          cpu_as_n = 1'b1;

  logic          ack_n;
  logic          stall;
  logic [6:0]    pad_oe;
  logic [AW-1:0] pad_addr;
  logic [DW-1:0] pad_dout;
  logic [CS-1:0] pad_cs_n;
  logic          pad_rd_n, pad_hwr_n, pad_lwr_n, pad_as_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_yield_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_req_n_i(ext_req_n),
    .cyc_t1_i(cyc_t1), .cyc_last_i(cyc_last),
    .sleep_i(sleep_q), .mod_all_stop_i(allstop),
    .cpu_addr_i(cpu_addr), .cpu_dout_i(cpu_dout), .cpu_dout_en_i(cpu_doe),
    .cpu_cs_n_i(cpu_cs_n), .cpu_rd_n_i(cpu_rd_n), .cpu_hwr_n_i(cpu_hwr_n),
    .cpu_lwr_n_i(cpu_lwr_n), .cpu_as_n_i(cpu_as_n),
    .bus_ack_n_o(ack_n), .cpu_stall_o(stall), .pad_oe_o(pad_oe),
    .pad_addr_o(pad_addr), .pad_dout_o(pad_dout), .pad_cs_n_o(pad_cs_n),
    .pad_rd_n_o(pad_rd_n), .pad_hwr_n_o(pad_hwr_n), .pad_lwr_n_o(pad_lwr_n),
    .pad_as_n_o(pad_as_n)
  );

  task automatic check(input string req, input int per, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s period=%0d actual=%0h expected=%0h", req, per, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ext_req_n = 1'b1; cyc_t1 = 1'b0; cyc_last = 1'b0;
    sleep_q = 1'b0; allstop = 1'b0; cpu_doe = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", -1, {61'd0, ack_n, stall, 1'b0}, {61'd0, 1'b1, 1'b0, 1'b0});
    check("R9", -1, {57'd0, pad_oe}, {57'd0, 7'h7f});
    rst_n = 1'b1;
  endtask

  // h: period in which the request is driven high again
  task automatic run_case(input string tag, input int L, input int r0, input int h,
                          input bit slp, input bit ast);
    bit blk;
    int p, pend, rel, ret, last, cyc_stop;
    bit rel_exp;
    bit e_ack, e_stall;
    logic [6:0] e_oe;
    blk = slp & ast;
    p = -1;
    for (int t = r0 + 2; t <= h + 1; t++) if (p < 0 && (t % L) == 0) p = t;
    rel_exp = !blk && (p >= 0);
    pend = p + 1;
    rel  = p + L;
    ret  = (rel + 1 > h + 3) ? rel + 1 : h + 3;
    if (rel_exp) begin
      last = ret + 2;
      cyc_stop = p + L - 1;
    end else begin
      last = (r0 + 3 * L + 8 > h + 4) ? r0 + 3 * L + 8 : h + 4;
      cyc_stop = last;
    end
    do_reset();
    for (int per = 0; per <= last; per++) begin
      @(negedge clk);
      e_ack   = !(rel_exp && per >= rel && per < ret);
      e_stall = rel_exp && per >= pend && per < ret;
      e_oe    = e_ack ? {5'b11111, cpu_doe, 1'b1} : 7'h00;
      check((rel_exp && per == ret) ? "R4" : tag, per, {63'd0, ack_n}, {63'd0, e_ack});
      check("R6", per, {63'd0, stall}, {63'd0, e_stall});
      check(e_ack ? "R8" : "R3", per, {57'd0, pad_oe}, {57'd0, e_oe});
      check("R8", per, {pad_addr, pad_dout, pad_cs_n, pad_rd_n, pad_hwr_n, pad_lwr_n, pad_as_n},
            {cpu_addr, cpu_dout, cpu_cs_n, cpu_rd_n, cpu_hwr_n, cpu_lwr_n, cpu_as_n});
      ext_req_n = !(per >= r0 && per < h);
      sleep_q = slp;
      allstop = ast;
      if (per <= cyc_stop) begin
        cyc_t1   = ((per % L) == 0);
        cyc_last = ((per % L) == L - 1);
        cpu_as_n = ((per % L) == 0);
        cpu_rd_n = ((per % L) == 0);
      end else begin
        cyc_t1 = 1'b0; cyc_last = 1'b0; cpu_as_n = 1'b1; cpu_rd_n = 1'b1;
      end
      cpu_addr  = AW'(per * 32'h1357 + L);
      cpu_dout  = DW'(per * 32'h0b1 + r0);
      cpu_doe   = per[0];
      cpu_cs_n  = CS'(~(per % 7));
      cpu_hwr_n = per[1];
      cpu_lwr_n = per[2];
    end
  endtask

  initial begin
    int p0;
    for (int L = 2; L <= 5; L++) begin
      for (int r0 = 0; r0 <= L; r0++) begin
        p0 = ((r0 + 2 + L - 1) / L) * L;
        // R2 and R7: long request under every qualifier combination
        for (int q = 0; q < 4; q++)
          run_case((q == 3) ? "R7" : "R2", L, r0, p0 + L + 2, q[0], q[1]);
        // R1: single-state request, taken only if it lands on a first state
        run_case("R1", L, r0, r0 + 1, 1'b0, 1'b0);
        // R5: request withdrawn while waiting for the cycle end
        run_case("R5", L, r0, p0 + 1, 1'b0, 1'b0);
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule